// File: doc/BRIEF.md
# Multi-Port MDIO Management Slave

This block is the serial management slave of a device that carries six identical port register banks behind one MDIO pin. It samples the data line on every rising edge of the management clock, hunts for a run of at least 32 ones, and then parses a clause-22 style frame: start field, opcode, 5-bit PHY address and 5-bit register address, turnaround and 16 data bits.

A strap input sets a base PHY address. The slave answers the six consecutive addresses that start at that base, and the offset from the base selects the port bank. The register banks are outside this block. They are reached through a plain strobe port that carries a port index, a register index, write data and combinational read data. On reads the slave releases the line for the first turnaround bit, drives a zero in the second, and then shifts the word out most significant bit first. Frames addressed outside the window, frames with a short preamble and malformed frames cause no access and leave the line released.

Top module: `mdio_hex_slave`

## Requirements
- R1: While rst_ni is low, mdio_oe_o, reg_rd_o and reg_wr_o are 0.
- R2: A frame is accepted only after at least 32 consecutive ones are sampled on mdio_i. A frame that follows 31 ones or fewer causes no strobe and leaves mdio_oe_o at 0.
- R3: The start field is 0 then 1. The read opcode is 1 then 0. For an accepted read, reg_rd_o is 1 for exactly the cycle that follows the rising edge that samples the last register-address bit. In that cycle reg_port_o equals the PHY address minus phy_base_i and reg_addr_o equals the register address. Both addresses are sent MSB first. reg_rdata_i is taken at the next rising edge.
- R4: On an accepted read, mdio_oe_o stays 0 while the first turnaround bit is sampled. After the rising edge that samples the first turnaround bit, it goes to 1 with mdio_o = 0. After each of the next 16 edges, mdio_o presents the read word from bit 15 down to bit 0. After the edge that samples bit 0, mdio_oe_o returns to 0, so the line is driven for 17 cycles.
- R5: The write opcode is 0 then 1. The master drives the two turnaround bits and then 16 data bits MSB first. reg_wr_o is 1 for exactly the cycle after the edge that samples the last data bit. In that cycle reg_port_o, reg_addr_o and reg_wdata_o carry the port, the register and the data.
- R6: PHY addresses phy_base_i + n for n = 0 to 5 select port n. No wrap-around past 31 is applied. Any other PHY address gives no strobe, and mdio_oe_o stays 0 for the whole frame.
- R7: A start field of 0 then 0, or an opcode of 0 then 0 or 1 then 1, ends the frame without any strobe. The parser then hunts for a new 32-one preamble.
- R8: mdio_o and mdio_oe_o change only at rising clock edges and are stable for the full cycle in which the master samples them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Management clock (MDC) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phy_base_i | input | 5 | Strapped base PHY address |
| mdio_i | input | 1 | Sampled management data line |
| mdio_o | output | 1 | Data driven onto the line during reads |
| mdio_oe_o | output | 1 | Output enable for the tri-state driver |
| reg_rd_o | output | 1 | One-cycle read request to the port banks |
| reg_wr_o | output | 1 | One-cycle write strobe to the port banks |
| reg_port_o | output | 3 | Selected port index |
| reg_addr_o | output | 5 | Selected register index |
| reg_wdata_o | output | 16 | Write data |
| reg_rdata_i | input | 16 | Read data from the selected register, combinational |

## Verification
Writes followed by read-backs to the lowest and highest port in the window check the offset-to-port mapping and the MSB-first ordering in both directions. A second base value places the window at the top of the address space. Frames addressed one below and one above the window, a 31-one preamble, a bad start field and both undefined opcodes must leave the driver off and the banks unchanged. The read-backs that follow show that no stray write reached a bank. A 40-one preamble and back-to-back frames show that extra ones are tolerated and that the parser re-arms cleanly after each frame.

// File: rtl/mdio_hex_pkg.sv
package mdio_hex_pkg;
  typedef enum logic [0:0] {PH_HUNT, PH_FRAME} phase_e;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
endpackage

// File: rtl/mdio_preamble_det.sv
module mdio_preamble_det #(
  parameter int PRE_LEN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hunt_i,
  input  logic mdio_i,
  output logic full_o
);
  localparam int CNT_W = $clog2(PRE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PRE_LEN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!hunt_i || !mdio_i) cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign full_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/mdio_addr_window.sv
module mdio_addr_window #(
  parameter int NUM_PORTS = 6,
  parameter int PHY_AW    = 5,
  parameter int PORT_W    = 3
) (
  input  logic [PHY_AW-1:0] base_i,
  input  logic [PHY_AW-1:0] phy_i,
  output logic              hit_o,
  output logic [PORT_W-1:0] port_o
);
  localparam int EW = PHY_AW + 1;

  logic [NUM_PORTS-1:0] hit;

  // extra bit keeps base+n from wrapping into low addresses
  for (genvar n = 0; n < NUM_PORTS; n++) begin : g_slot
    assign hit[n] = ({1'b0, phy_i} == ({1'b0, base_i} + EW'(n)));
  end

  always_comb begin
    port_o = '0;
    for (int n = 0; n < NUM_PORTS; n++) begin
      if (hit[n]) port_o = PORT_W'(n);
    end
  end

  assign hit_o = |hit;
endmodule

// File: rtl/mdio_read_shifter.sv
module mdio_read_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              stop_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      mdio_o    <= 1'b0;
      mdio_oe_o <= 1'b0;
    end else if (load_i) begin
      sh_q      <= data_i;
      mdio_o    <= 1'b0;
      mdio_oe_o <= 1'b1;
    end else if (shift_i) begin
      mdio_o <= sh_q[DATA_W-1];
      sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
    end else if (stop_i) begin
      mdio_o    <= 1'b0;
      mdio_oe_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_frame_parser.sv
module mdio_frame_parser
  import mdio_hex_pkg::*;
#(
  parameter int PHY_AW = 5,
  parameter int REG_AW = 5,
  parameter int DATA_W = 16,
  parameter int PORT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mdio_i,
  input  logic              pre_full_i,
  input  logic              win_hit_i,
  input  logic [PORT_W-1:0] win_port_i,
  output logic [PHY_AW-1:0] phy_o,
  output logic              hunt_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [PORT_W-1:0] port_o,
  output logic [REG_AW-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              load_o,
  output logic              shift_o,
  output logic              stop_o
);
  localparam int OP_END_I = 3;
  localparam int A_END_I  = OP_END_I + PHY_AW;
  localparam int R_END_I  = A_END_I + REG_AW;
  localparam int TA1_I    = R_END_I + 1;
  localparam int TA2_I    = R_END_I + 2;
  localparam int D_END_I  = TA2_I + DATA_W;
  localparam int IDX_W    = $clog2(D_END_I + 1);

  localparam logic [IDX_W-1:0] I_ST1   = IDX_W'(1);
  localparam logic [IDX_W-1:0] I_OP0   = IDX_W'(2);
  localparam logic [IDX_W-1:0] I_OPEND = IDX_W'(OP_END_I);
  localparam logic [IDX_W-1:0] I_AEND  = IDX_W'(A_END_I);
  localparam logic [IDX_W-1:0] I_REND  = IDX_W'(R_END_I);
  localparam logic [IDX_W-1:0] I_TA1   = IDX_W'(TA1_I);
  localparam logic [IDX_W-1:0] I_TA2   = IDX_W'(TA2_I);
  localparam logic [IDX_W-1:0] I_DEND  = IDX_W'(D_END_I);

  phase_e             phase_q;
  logic [IDX_W-1:0]   idx_q;
  logic               op_q;
  logic               is_rd_q;
  logic               acc_q;
  logic [PORT_W-1:0]  pend_port_q;
  logic [PHY_AW-2:0]  phy_sr_q;
  logic [REG_AW-2:0]  reg_sr_q;
  logic [DATA_W-2:0]  wsh_q;
  logic [REG_AW-1:0]  reg_next;
  logic [1:0]         op_next;
  logic               in_frame;

  assign in_frame = (phase_q == PH_FRAME);
  assign hunt_o   = (phase_q == PH_HUNT);
  assign phy_o    = {phy_sr_q, mdio_i};
  assign reg_next = {reg_sr_q, mdio_i};
  assign op_next  = {op_q, mdio_i};

  assign load_o  = in_frame && acc_q && is_rd_q && (idx_q == I_TA1);
  assign shift_o = in_frame && acc_q && is_rd_q && (idx_q >= I_TA2) && (idx_q < I_DEND);
  assign stop_o  = in_frame && (idx_q == I_DEND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_HUNT;
      idx_q       <= '0;
      op_q        <= 1'b0;
      is_rd_q     <= 1'b0;
      acc_q       <= 1'b0;
      pend_port_q <= '0;
      phy_sr_q    <= '0;
      reg_sr_q    <= '0;
      wsh_q       <= '0;
      rd_o        <= 1'b0;
      wr_o        <= 1'b0;
      port_o      <= '0;
      addr_o      <= '0;
      wdata_o     <= '0;
    end else begin
      rd_o <= 1'b0;
      wr_o <= 1'b0;
      if (!in_frame) begin
        // a zero after a full preamble is the first start bit
        if (!mdio_i && pre_full_i) begin
          phase_q <= PH_FRAME;
          idx_q   <= I_ST1;
          acc_q   <= 1'b0;
        end
      end else begin
        idx_q <= idx_q + IDX_W'(1);
        if (idx_q == I_ST1 && !mdio_i) phase_q <= PH_HUNT;
        if (idx_q == I_OP0) op_q <= mdio_i;
        if (idx_q == I_OPEND) begin
          if (op_next == OPC_READ || op_next == OPC_WRITE) is_rd_q <= (op_next == OPC_READ);
          else phase_q <= PH_HUNT;
        end
        if (idx_q > I_OPEND && idx_q <= I_AEND) phy_sr_q <= phy_o[PHY_AW-2:0];
        if (idx_q == I_AEND) begin
          acc_q       <= win_hit_i;
          pend_port_q <= win_port_i;
        end
        if (idx_q > I_AEND && idx_q <= I_REND) reg_sr_q <= reg_next[REG_AW-2:0];
        if (idx_q == I_REND && acc_q) begin
          port_o <= pend_port_q;
          addr_o <= reg_next;
          rd_o   <= is_rd_q;
        end
        if (idx_q > I_TA2 && idx_q <= I_DEND) wsh_q <= {wsh_q[DATA_W-3:0], mdio_i};
        if (idx_q == I_DEND) begin
          phase_q <= PH_HUNT;
          if (acc_q && !is_rd_q) begin
            wr_o    <= 1'b1;
            wdata_o <= {wsh_q, mdio_i};
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_hex_slave.sv
module mdio_hex_slave #(
  parameter int NUM_PORTS = 6,
  parameter int PHY_AW    = 5,
  parameter int REG_AW    = 5,
  parameter int DATA_W    = 16,
  parameter int PRE_LEN   = 32,
  localparam int PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PHY_AW-1:0] phy_base_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [PORT_W-1:0] reg_port_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic              pre_full, hunt, win_hit;
  logic              load, shift, stop;
  logic [PORT_W-1:0] win_port;
  logic [PHY_AW-1:0] phy_cur;

  mdio_preamble_det #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hunt_i (hunt),
    .mdio_i (mdio_i),
    .full_o (pre_full)
  );

  mdio_addr_window #(.NUM_PORTS(NUM_PORTS), .PHY_AW(PHY_AW), .PORT_W(PORT_W)) u_win (
    .base_i (phy_base_i),
    .phy_i  (phy_cur),
    .hit_o  (win_hit),
    .port_o (win_port)
  );

  mdio_frame_parser #(.PHY_AW(PHY_AW), .REG_AW(REG_AW), .DATA_W(DATA_W), .PORT_W(PORT_W)) u_prs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mdio_i     (mdio_i),
    .pre_full_i (pre_full),
    .win_hit_i  (win_hit),
    .win_port_i (win_port),
    .phy_o      (phy_cur),
    .hunt_o     (hunt),
    .rd_o       (reg_rd_o),
    .wr_o       (reg_wr_o),
    .port_o     (reg_port_o),
    .addr_o     (reg_addr_o),
    .wdata_o    (reg_wdata_o),
    .load_o     (load),
    .shift_o    (shift),
    .stop_o     (stop)
  );

  mdio_read_shifter #(.DATA_W(DATA_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .shift_i   (shift),
    .stop_i    (stop),
    .data_i    (reg_rdata_i),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );
endmodule

// File: rtl/mdio_hex_slave_chk.sv
module mdio_hex_slave_chk #(
  parameter int NUM_PORTS = 6,
  parameter int DATA_W    = 16,
  parameter int PORT_W    = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mdio_o,
  input logic              mdio_oe_o,
  input logic              reg_rd_o,
  input logic              reg_wr_o,
  input logic [PORT_W-1:0] reg_port_o
);
  localparam int LW = $clog2(DATA_W + 3) + 1;
  localparam logic [LW-1:0] DRIVE_LEN = LW'(DATA_W + 1);

  logic [LW-1:0] oe_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_len_q <= '0;
    else if (mdio_oe_o) oe_len_q <= oe_len_q + LW'(1);
    else oe_len_q <= '0;
  end

  assert_ta_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> (mdio_oe_o && !mdio_o));

  assert_drive_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdio_oe_o) |-> (oe_len_q == DRIVE_LEN));

  assert_oe_needs_rd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> $past(reg_rd_o));

  assert_wr_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);

  assert_wr_quiet_line_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> !mdio_oe_o);

  assert_port_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_o || reg_wr_o) |-> (int'(reg_port_o) < NUM_PORTS));
endmodule

bind mdio_hex_slave mdio_hex_slave_chk #(
  .NUM_PORTS (NUM_PORTS),
  .DATA_W    (DATA_W),
  .PORT_W    (PORT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mdio_o     (mdio_o),
  .mdio_oe_o  (mdio_oe_o),
  .reg_rd_o   (reg_rd_o),
  .reg_wr_o   (reg_wr_o),
  .reg_port_o (reg_port_o)
);

// File: tb/sim_mdio_hex_slave.sv
`timescale 1ns/1ps
module sim_mdio_hex_slave;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  base;
  logic        mdio_in;
  logic        mdio_out, mdio_oe, rd, wr;
  logic [2:0]  port;
  logic [4:0]  addr;
  logic [15:0] wdata, rdata;

  logic [15:0] bank    [8][32];
  logic [15:0] ref_mem [6][32];

  int n_chk = 0;
  int n_fail = 0;
  logic last_oe = 1'b0;
  logic last_do = 1'b0;

  always #2 clk = ~clk;

  mdio_hex_slave u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .phy_base_i  (base),
    .mdio_i      (mdio_in),
    .mdio_o      (mdio_out),
    .mdio_oe_o   (mdio_oe),
    .reg_rd_o    (rd),
    .reg_wr_o    (wr),
    .reg_port_o  (port),
    .reg_addr_o  (addr),
    .reg_wdata_o (wdata),
    .reg_rdata_i (rdata)
  );

  assign rdata = bank[port][addr];
  always @(posedge clk) if (wr) bank[port][addr] <= wdata;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input bit b, input bit e_oe, input bit e_do, input bit e_rd, input bit e_wr,
                      input string ro, input string rr, input string rw,
                      input int e_port, input int e_addr, input int e_wd);
    @(negedge clk);
    chk(mdio_oe == last_oe, "R8", "oe mid-cycle", int'(mdio_oe), int'(last_oe));
    if (last_oe) chk(mdio_out == last_do, "R8", "data mid-cycle", int'(mdio_out), int'(last_do));
    mdio_in = b;
    @(posedge clk);
    #1;
    chk(mdio_oe == e_oe, ro, "mdio_oe_o", int'(mdio_oe), int'(e_oe));
    if (e_oe) chk(mdio_out == e_do, ro, "mdio_o", int'(mdio_out), int'(e_do));
    chk(rd == e_rd, rr, "reg_rd_o", int'(rd), int'(e_rd));
    chk(wr == e_wr, rw, "reg_wr_o", int'(wr), int'(e_wr));
    if (e_rd || e_wr) begin
      chk(int'(port) == e_port, e_rd ? rr : rw, "reg_port_o", int'(port), e_port);
      chk(int'(addr) == e_addr, e_rd ? rr : rw, "reg_addr_o", int'(addr), e_addr);
    end
    if (e_wr) chk(int'(wdata) == e_wd, rw, "reg_wdata_o", int'(wdata), e_wd);
    last_oe = mdio_oe;
    last_do = mdio_out;
  endtask

  task automatic idle();
    tick(1'b0, 0, 0, 0, 0, "R2", "R2", "R2", 0, 0, 0);
  endtask

  // reference: build the bit stream and the expected outputs after each edge
  task automatic frame(input int pre, input bit [1:0] st, input bit [1:0] op,
                       input int phy, input int ra, input logic [15:0] wd, input string tag);
    bit q[$];
    int off;
    bit go, rdf, wrf;
    logic [15:0] rdat;
    string ro, rr, rw;
    off  = phy - int'(base);
    go   = (pre >= 32) && (st == 2'b01) && (op == 2'b10 || op == 2'b01) && off >= 0 && off < 6;
    rdf  = go && op == 2'b10;
    wrf  = go && op == 2'b01;
    rdat = '0;
    if (rdf) rdat = ref_mem[off][ra];
    ro = (tag != "") ? tag : "R4";
    rr = (tag != "") ? tag : "R3";
    rw = (tag != "") ? tag : "R5";
    q.push_back(st[1]); q.push_back(st[0]);
    q.push_back(op[1]); q.push_back(op[0]);
    for (int i = 4; i >= 0; i--) q.push_back(phy[i]);
    for (int i = 4; i >= 0; i--) q.push_back(ra[i]);
    q.push_back(1'b1);
    q.push_back(op == 2'b01 ? 1'b0 : 1'b1);
    for (int i = 15; i >= 0; i--) q.push_back(op == 2'b01 ? wd[i] : 1'b1);
    for (int i = 0; i < pre; i++) tick(1'b1, 0, 0, 0, 0, ro, rr, rw, 0, 0, 0);
    for (int k = 0; k < 32; k++) begin
      bit e_oe, e_do, e_rd, e_wr;
      e_rd = rdf && k == 13;
      e_oe = rdf && k >= 14 && k <= 30;
      e_do = (k >= 15 && k <= 30) ? rdat[30-k] : 1'b0;
      e_wr = wrf && k == 31;
      tick(q[k], e_oe, e_do, e_rd, e_wr, ro, rr, rw, off, ra, int'(wd));
    end
    if (wrf) ref_mem[off][ra] = wd;
    idle();
  endtask

  initial begin
    for (int p = 0; p < 8; p++)
      for (int r = 0; r < 32; r++) bank[p][r] = 16'(p * 4096 + r * 97 + 16'h0311);
    for (int p = 0; p < 6; p++)
      for (int r = 0; r < 32; r++) ref_mem[p][r] = 16'(p * 4096 + r * 97 + 16'h0311);
    rst_n   = 1'b0;
    base    = 5'd4;
    mdio_in = 1'b1;
    #10;
    chk(mdio_oe == 1'b0, "R1", "oe in reset", int'(mdio_oe), 0);
    chk(rd == 1'b0, "R1", "rd in reset", int'(rd), 0);
    chk(wr == 1'b0, "R1", "wr in reset", int'(wr), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle();

    // R5 / R3 / R4: lowest and highest port in the window
    frame(32, 2'b01, 2'b01, 4, 3, 16'hA5C3, "");
    frame(32, 2'b01, 2'b10, 4, 3, 16'h0, "");
    frame(32, 2'b01, 2'b01, 9, 31, 16'h8001, "");
    frame(32, 2'b01, 2'b10, 9, 31, 16'h0, "");
    frame(32, 2'b01, 2'b10, 6, 0, 16'h0, "");
    // R6: just outside the window on both sides
    frame(32, 2'b01, 2'b01, 10, 3, 16'h1111, "R6");
    frame(32, 2'b01, 2'b01, 3, 3, 16'h2222, "R6");
    frame(32, 2'b01, 2'b10, 10, 3, 16'h0, "R6");
    frame(32, 2'b01, 2'b10, 3, 3, 16'h0, "R6");
    frame(32, 2'b01, 2'b10, 4, 3, 16'h0, "");
    // R2: one-short preamble
    frame(31, 2'b01, 2'b01, 5, 7, 16'hDEAD, "R2");
    frame(32, 2'b01, 2'b10, 5, 7, 16'h0, "");
    // R7: bad start field and both undefined opcodes
    frame(32, 2'b00, 2'b01, 5, 7, 16'hBEEF, "R7");
    frame(32, 2'b01, 2'b11, 5, 7, 16'hBEEF, "R7");
    frame(32, 2'b01, 2'b00, 5, 7, 16'hBEEF, "R7");
    frame(32, 2'b01, 2'b10, 5, 7, 16'h0, "");
    // long preamble
    frame(40, 2'b01, 2'b01, 7, 12, 16'h5A5A, "");
    frame(40, 2'b01, 2'b10, 7, 12, 16'h0, "");
    // R6: window at the top of the address space
    @(negedge clk);
    base = 5'd26;
    frame(32, 2'b01, 2'b01, 31, 0, 16'h7E81, "");
    frame(32, 2'b01, 2'b10, 31, 0, 16'h0, "");
    frame(32, 2'b01, 2'b10, 26, 31, 16'h0, "");
    frame(32, 2'b01, 2'b01, 25, 0, 16'h3333, "R6");
    frame(32, 2'b01, 2'b10, 26, 0, 16'h0, "");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule